// File: doc/BRIEF.md
# Codec Parallel Host Bus Interface

This block is the host-facing front end of a stereo audio codec attached to an 8-bit parallel bus. One pair of active-low read and write strobes carries two kinds of cycle. Register cycles are qualified by an active-low chip select and reach one of four direct registers through a 2-bit address. DMA cycles are qualified by one of two active-low acknowledge inputs, one for capture and one for playback. Chip select plays no part in a DMA cycle.

Capture samples arrive from a stand-in converter port and queue in a capture FIFO, which the host drains with DMA reads. The host fills a playback FIFO with DMA writes, and a stand-in output port drains it. Two active-high request outputs tell the host when each FIFO needs service. The block also drives the enable and direction pins of an external bus transceiver, plus an output-enable for its own read data.

All bus control inputs pass through two-flop synchronisers. Each FIFO push or pop happens once per strobe, on the synchronised falling edge. After a control input changes, the transceiver outputs follow on the third rising clock edge.

Top module: `codec_host_bus`

## Requirements
- R1: `xcvr_en_n` is high at rest. It is low when (read or write strobe low) and (chip select low or either acknowledge low), using the inputs seen two clocks earlier. It is registered, so it follows an input change at the third rising edge.
- R2: `xcvr_dir` is high at rest (host to device). It is low when the read strobe is low and (chip select low or either acknowledge low), with the same latency as R1.
- R3: `rdata_oe` is high only while `xcvr_en_n` and `xcvr_dir` are both low.
- R4: A register cycle needs chip select low and both acknowledges high. Address 0 and address 1 are read/write 8-bit scratch registers. Address 2 is status: bit 0 is the capture underrun flag and bit 1 is the playback overrun flag, and writing 1 to a bit clears it. Address 3 reads the capture FIFO fill count in bits 4:0, and writes to it are ignored. Strobes while chip select is high reach no register.
- R5: `adc_valid` pushes `adc_data` into the 16-entry capture FIFO, and the push is dropped when the FIFO is full. Each read strobe with `cap_ack_n` low pops one entry, in arrival order, onto `rdata`. Chip select does not matter for this.
- R6: `cap_req` is high exactly while the capture FIFO holds at least one entry.
- R7: Each write strobe with `play_ack_n` low pushes `wdata` into the 16-entry playback FIFO. A high `dac_take` pops one entry when the FIFO is not empty. On the next cycle `dac_valid` pulses with that entry on `dac_data`, in write order.
- R8: `play_req` is high exactly while the playback FIFO holds fewer than 16 entries.
- R9: A DMA read from an empty capture FIFO leaves `rdata` at the last value popped and sets the sticky underrun flag.
- R10: A DMA write to a full playback FIFO is dropped and sets the sticky overrun flag. The flag stays set until it is cleared through the status register.
- R11: When an acknowledge and chip select are both low during a strobe, the DMA cycle takes place and the register access is suppressed.
- R12: After reset, `xcvr_en_n` and `xcvr_dir` are 1, `rdata_oe`, `cap_req` and `dac_valid` are 0, `play_req` is 1, and all registers and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select for register cycles, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_addr | input | 2 | Direct register address |
| cap_ack_n | input | 1 | Capture DMA acknowledge, active low |
| play_ack_n | input | 1 | Playback DMA acknowledge, active low |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data to host |
| rdata_oe | output | 1 | Read data drive enable |
| xcvr_en_n | output | 1 | External transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, high = host to device |
| cap_req | output | 1 | Capture DMA request |
| play_req | output | 1 | Playback DMA request |
| adc_valid | input | 1 | Capture sample strobe |
| adc_data | input | 8 | Capture sample |
| dac_take | input | 1 | Playback sample demand |
| dac_valid | output | 1 | Playback sample valid pulse |
| dac_data | output | 8 | Playback sample |

## Verification
The assertions check these relations on every cycle:
- Direction is never low while the enable is high.
- The data output-enable never rises outside a transceiver read.
- A sticky flag only rises after its FIFO was empty (underrun) or full (overrun).
- A cycle qualified by an acknowledge never alters a scratch register.
- Each FIFO level stays within depth and moves by at most one per clock.

Only the bench scenarios, compared clock by clock against a queue-based model, can show the rest:
- the exact three-edge latency of the outputs;
- data ordering through both FIFOs;
- last-value return on underrun;
- write-1-to-clear of the status flags;
- chip select being ignored during DMA.

// File: rtl/codec_bus_pkg.sv
`timescale 1ns/1ps
package codec_bus_pkg;
  localparam int DATA_W = 8;
  localparam logic [1:0] ADDR_SCR0  = 2'd0;
  localparam logic [1:0] ADDR_SCR1  = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
  localparam logic [1:0] ADDR_LEVEL = 2'd3;
endpackage

// File: rtl/cbi_sync.sv
`timescale 1ns/1ps
module cbi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cbi_fifo.sv
`timescale 1ns/1ps
module cbi_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign do_push = push && (level != FULL_LVL);
  assign do_pop  = pop && (level != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      dout  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      if (do_pop) begin
        dout <= mem[rptr];
        rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) level <= FULL_LVL);
  // R5
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (level == $past(level)) || (level == $past(level) + 1'b1) || (level + 1'b1 == $past(level)));
endmodule

// File: rtl/codec_host_bus.sv
`timescale 1ns/1ps
module codec_host_bus
  import codec_bus_pkg::*;
#(
  parameter int CAP_DEPTH  = 16,
  parameter int PLAY_DEPTH = 16,
  localparam int CLW = $clog2(CAP_DEPTH) + 1,
  localparam int PLW = $clog2(PLAY_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        reg_addr,
  input  logic              cap_ack_n,
  input  logic              play_ack_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              xcvr_en_n,
  output logic              xcvr_dir,
  output logic              cap_req,
  output logic              play_req,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              dac_take,
  output logic              dac_valid,
  output logic [DATA_W-1:0] dac_data
);
  logic [6:0] raw_ctl, syn_ctl;
  logic s_cs, s_rd, s_wr, s_cack, s_pack;
  logic [1:0] s_addr;
  logic prev_rd, prev_wr;
  logic rd_fall, wr_fall, dma_sel, reg_sel, any_sel;
  logic cap_pop, play_push, reg_rd, reg_wr;
  logic [CLW-1:0] cap_level;
  logic [PLW-1:0] play_level;
  logic cap_empty, play_empty, play_full;
  logic [DATA_W-1:0] cap_dout, reg_q, reg_mux, scr0_q, scr1_q;
  logic unr_q, ovr_q, sel_dma_q, en_n_q, dir_q, oe_q, dac_valid_q;

  assign raw_ctl = {reg_addr, play_ack_n, cap_ack_n, wr_n, rd_n, cs_n};

  cbi_sync #(.W(7), .RST_VAL(7'h7F)) u_sync (
    .clk(clk), .rst(rst), .d(raw_ctl), .q(syn_ctl)
  );

  assign s_cs   = syn_ctl[0];
  assign s_rd   = syn_ctl[1];
  assign s_wr   = syn_ctl[2];
  assign s_cack = syn_ctl[3];
  assign s_pack = syn_ctl[4];
  assign s_addr = syn_ctl[6:5];

  assign rd_fall   = prev_rd & ~s_rd;
  assign wr_fall   = prev_wr & ~s_wr;
  assign dma_sel   = ~s_cack | ~s_pack;
  assign reg_sel   = ~s_cs & ~dma_sel;
  assign any_sel   = ~s_cs | dma_sel;
  assign cap_pop   = rd_fall & ~s_cack;
  assign play_push = wr_fall & ~s_pack;
  assign reg_rd    = rd_fall & reg_sel;
  assign reg_wr    = wr_fall & reg_sel;

  cbi_fifo #(.W(DATA_W), .DEPTH(CAP_DEPTH)) u_cap_fifo (
    .clk(clk), .rst(rst), .push(adc_valid), .din(adc_data),
    .pop(cap_pop), .dout(cap_dout), .level(cap_level)
  );

  cbi_fifo #(.W(DATA_W), .DEPTH(PLAY_DEPTH)) u_play_fifo (
    .clk(clk), .rst(rst), .push(play_push), .din(wdata),
    .pop(dac_take), .dout(dac_data), .level(play_level)
  );

  assign cap_empty  = (cap_level == '0);
  assign play_empty = (play_level == '0);
  assign play_full  = (play_level == PLW'(PLAY_DEPTH));

  always_comb begin
    case (s_addr)
      ADDR_SCR0: reg_mux = scr0_q;
      ADDR_SCR1: reg_mux = scr1_q;
      ADDR_STAT: reg_mux = {{(DATA_W-2){1'b0}}, ovr_q, unr_q};
      default:   reg_mux = DATA_W'(cap_level);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rd     <= 1'b1;
      prev_wr     <= 1'b1;
      en_n_q      <= 1'b1;
      dir_q       <= 1'b1;
      oe_q        <= 1'b0;
      reg_q       <= '0;
      sel_dma_q   <= 1'b0;
      scr0_q      <= '0;
      scr1_q      <= '0;
      unr_q       <= 1'b0;
      ovr_q       <= 1'b0;
      dac_valid_q <= 1'b0;
    end else begin
      prev_rd <= s_rd;
      prev_wr <= s_wr;
      en_n_q  <= ~((~s_rd | ~s_wr) & any_sel);
      dir_q   <= ~(~s_rd & any_sel);
      oe_q    <= ~s_rd & any_sel;
      if (reg_rd) begin
        reg_q     <= reg_mux;
        sel_dma_q <= 1'b0;
      end
      if (cap_pop) sel_dma_q <= 1'b1;
      if (reg_wr && s_addr == ADDR_SCR0) scr0_q <= wdata;
      if (reg_wr && s_addr == ADDR_SCR1) scr1_q <= wdata;
      unr_q <= (cap_pop & cap_empty) |
               (unr_q & ~(reg_wr & (s_addr == ADDR_STAT) & wdata[0]));
      ovr_q <= (play_push & play_full) |
               (ovr_q & ~(reg_wr & (s_addr == ADDR_STAT) & wdata[1]));
      dac_valid_q <= dac_take & ~play_empty;
    end
  end

  assign rdata     = sel_dma_q ? cap_dout : reg_q;
  assign rdata_oe  = oe_q;
  assign xcvr_en_n = en_n_q;
  assign xcvr_dir  = dir_q;
  assign cap_req   = ~cap_empty;
  assign play_req  = ~play_full;
  assign dac_valid = dac_valid_q;

  // R2
  dir_needs_en_chk: assert property (@(posedge clk) disable iff (rst) !xcvr_dir |-> !xcvr_en_n);
  // R3
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst) rdata_oe |-> (!xcvr_en_n && !xcvr_dir));
  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(unr_q) |-> $past(!cap_req));
  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(ovr_q) |-> $past(!play_req));
  // R11
  dma_blocks_reg_chk: assert property (@(posedge clk) disable iff (rst)
    dma_sel |=> ($stable(scr0_q) && $stable(scr1_q)));
endmodule

// File: tb/codec_host_bus_test.sv
`timescale 1ns/1ps
module codec_host_bus_test;
  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1, cap_ack_n = 1, play_ack_n = 1;
  logic [1:0] reg_addr = 0;
  logic [7:0] wdata = 0, adc_data = 0;
  logic adc_valid = 0, dac_take = 0;
  logic [7:0] rdata, dac_data;
  logic rdata_oe, xcvr_en_n, xcvr_dir, cap_req, play_req, dac_valid;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  codec_host_bus uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .reg_addr(reg_addr),
    .cap_ack_n(cap_ack_n), .play_ack_n(play_ack_n), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir), .cap_req(cap_req),
    .play_req(play_req), .adc_valid(adc_valid), .adc_data(adc_data), .dac_take(dac_take),
    .dac_valid(dac_valid), .dac_data(dac_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: inputs reach the decision logic two clocks late,
  // decisions land on the following edge.
  logic [7:0] capq[$], playq[$];
  int h1_cs, h1_rd, h1_wr, h1_ca, h1_pa, h1_ad;
  int s_cs, s_rd, s_wr, s_ca, s_pa, s_ad, p_rd, p_wr;
  int e_en, e_dir, e_oe, e_sel, e_dval, unr, ovr;
  logic [7:0] r0, r1, reg_last, cap_last, dac_last;

  always @(posedge clk) begin
    if (rst) begin
      capq.delete(); playq.delete();
      {h1_cs, h1_rd, h1_wr, h1_ca, h1_pa} = {5{32'd1}}; h1_ad = 3;
      {s_cs, s_rd, s_wr, s_ca, s_pa, p_rd, p_wr} = {7{32'd1}}; s_ad = 3;
      e_en = 1; e_dir = 1; e_oe = 0; e_sel = 0; e_dval = 0; unr = 0; ovr = 0;
      r0 = 0; r1 = 0; reg_last = 0; cap_last = 0; dac_last = 0;
    end else begin
      int rf, wf, dma, regc, sel, capn, playn, nu, no;
      rf = p_rd && !s_rd; wf = p_wr && !s_wr;
      dma = !s_ca || !s_pa; regc = !s_cs && !dma; sel = !s_cs || dma;
      capn = capq.size(); playn = playq.size();
      nu = unr; no = ovr;
      e_en = !((!s_rd || !s_wr) && sel);
      e_dir = !(!s_rd && sel);
      e_oe = !s_rd && sel;
      if (rf && regc) begin
        e_sel = 0;
        case (s_ad)
          0: reg_last = r0;
          1: reg_last = r1;
          2: reg_last = {6'd0, ovr[0], unr[0]};
          default: reg_last = 8'(capn);
        endcase
      end
      if (rf && !s_ca) begin
        e_sel = 1;
        if (capn > 0) cap_last = capq.pop_front(); else nu = 1;
      end
      if (wf && regc) begin
        if (s_ad == 0) r0 = wdata;
        if (s_ad == 1) r1 = wdata;
        if (s_ad == 2) begin
          if (wdata[0] && !(rf && !s_ca && capn == 0)) nu = 0;
          if (wdata[1]) no = 0;
        end
      end
      if (wf && !s_pa) begin
        if (playn < 16) playq.push_back(wdata); else no = 1;
      end
      unr = nu; ovr = no;
      if (adc_valid && capn < 16) capq.push_back(adc_data);
      if (dac_take && playn > 0) begin dac_last = playq.pop_front(); e_dval = 1; end
      else e_dval = 0;
      p_rd = s_rd; p_wr = s_wr;
      s_cs = h1_cs; s_rd = h1_rd; s_wr = h1_wr; s_ca = h1_ca; s_pa = h1_pa; s_ad = h1_ad;
      h1_cs = cs_n; h1_rd = rd_n; h1_wr = wr_n; h1_ca = cap_ack_n; h1_pa = play_ack_n; h1_ad = reg_addr;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 xcvr_en_n", xcvr_en_n, e_en[0]);
      chk("R2 xcvr_dir", xcvr_dir, e_dir[0]);
      chk("R3 rdata_oe", rdata_oe, e_oe[0]);
      if (e_sel) chk("R5 rdata capture", rdata, cap_last);
      else       chk("R4 rdata register", rdata, reg_last);
      chk("R6 cap_req", cap_req, capq.size() != 0);
      chk("R8 play_req", play_req, playq.size() != 16);
      chk("R7 dac_valid", dac_valid, e_dval[0]);
      if (dac_valid) chk("R7 dac_data", dac_data, dac_last);
    end
  end

  task automatic cyc(input bit is_rd, input bit cs, input bit ca, input bit pa,
                     input logic [1:0] a, input logic [7:0] d, output logic [7:0] got);
    @(negedge clk);
    cs_n = !cs; cap_ack_n = !ca; play_ack_n = !pa; reg_addr = a; wdata = d;
    @(negedge clk);
    if (is_rd) rd_n = 0; else wr_n = 0;
    repeat (4) @(negedge clk);
    got = rdata;
    rd_n = 1; wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1; cap_ack_n = 1; play_ack_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic adc_push(input logic [7:0] d);
    @(negedge clk); adc_valid = 1; adc_data = d;
    @(negedge clk); adc_valid = 0;
  endtask

  logic [7:0] g;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 en_n", xcvr_en_n, 1); chk("R12 dir", xcvr_dir, 1);
    chk("R12 oe", rdata_oe, 0);    chk("R12 cap_req", cap_req, 0);
    chk("R12 play_req", play_req, 1); chk("R12 dac_valid", dac_valid, 0);
    cyc(1, 1, 0, 0, 2'd0, 8'h00, g); chk("R12 scratch0", g, 8'h00);

    // R4 scratch registers and chip-select gating
    cyc(0, 1, 0, 0, 2'd0, 8'hA5, g);
    cyc(0, 1, 0, 0, 2'd1, 8'h3C, g);
    cyc(1, 1, 0, 0, 2'd0, 8'h00, g); chk("R4 scratch0", g, 8'hA5);
    cyc(1, 1, 0, 0, 2'd1, 8'h00, g); chk("R4 scratch1", g, 8'h3C);
    cyc(0, 0, 0, 0, 2'd0, 8'h11, g);
    cyc(1, 1, 0, 0, 2'd0, 8'h00, g); chk("R4 cs high ignored", g, 8'hA5);
    cyc(0, 1, 0, 0, 2'd3, 8'hFF, g);

    // R5/R6 capture path
    adc_push(8'h21); adc_push(8'h42); adc_push(8'h63);
    @(negedge clk); chk("R6 cap_req set", cap_req, 1);
    cyc(1, 1, 0, 0, 2'd3, 8'h00, g); chk("R5 level", g, 8'd3);
    cyc(1, 0, 1, 0, 2'd0, 8'h00, g); chk("R5 pop1", g, 8'h21);
    cyc(1, 1, 1, 0, 2'd0, 8'h00, g); chk("R11 pop2 cs ignored", g, 8'h42);
    cyc(1, 0, 1, 0, 2'd0, 8'h00, g); chk("R5 pop3", g, 8'h63);
    chk("R6 cap_req clear", cap_req, 0);

    // R9 underrun
    cyc(1, 0, 1, 0, 2'd0, 8'h00, g); chk("R9 last value", g, 8'h63);
    cyc(1, 1, 0, 0, 2'd2, 8'h00, g); chk("R9 flag", g, 8'h01);
    cyc(0, 1, 0, 0, 2'd2, 8'h01, g);
    cyc(1, 1, 0, 0, 2'd2, 8'h00, g); chk("R4 flag cleared", g, 8'h00);

    // R7/R8/R10 playback path
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 2'd0, 8'(8'h80 + i), g);
    chk("R8 full", play_req, 0);
    cyc(0, 0, 0, 1, 2'd0, 8'hEE, g);
    cyc(1, 1, 0, 0, 2'd2, 8'h00, g); chk("R10 flag", g, 8'h02);
    cyc(1, 1, 0, 0, 2'd2, 8'h00, g); chk("R10 sticky", g, 8'h02);
    @(negedge clk); dac_take = 1;
    repeat (20) @(negedge clk);
    dac_take = 0;
    chk("R8 drained", play_req, 1);
    cyc(0, 1, 0, 0, 2'd2, 8'h02, g);
    cyc(1, 1, 0, 0, 2'd2, 8'h00, g); chk("R10 cleared", g, 8'h00);

    // R11 DMA wins over register write
    cyc(0, 1, 0, 1, 2'd0, 8'h5A, g);
    cyc(1, 1, 0, 0, 2'd0, 8'h00, g); chk("R11 scratch0 kept", g, 8'hA5);
    @(negedge clk); dac_take = 1;
    repeat (3) @(negedge clk); dac_take = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule